// File: doc/BRIEF.md
# Header-Filtered Downlink Command Dispatcher

This block sits behind the downlink demodulator of an implanted stimulator/recorder chip. It watches one framed byte stream and routes each complete packet to one of two consumers: the stimulation controller or the recording controller. The first byte of a packet carries a class code and a chip address. A packet is accepted only if the class code belongs to one of the two controllers, the address matches the strapped chip ID, the length fits that class exactly, and every byte arrived while the uplink gap window was open. A packet that fails any of these checks is dropped as a whole. Bytes corrupted by the chip's own uplink therefore never reach a controller.

A recording packet carries two configuration bytes and four stimulation-parameter bytes. Bit 7 of the first configuration byte switches concurrent record-and-stimulate mode. While that mode is on, the stimulation port takes its parameters only from recording packets, and direct stimulation packets from the radio are refused. Each output port has a one-cycle valid strobe and holds its data between strobes.

Top module: `cmd_dispatch`

## Requirements
- R1: The header byte holds a class code in bits 7:2 and a chip address in bits 1:0. Code 6'b010101 selects the stimulation controller and code 6'b101010 selects the recording controller. A packet with any other code is dropped.
- R2: A packet is accepted only when header bits 1:0 equal the `chip_id` input.
- R3: A packet starts with a byte marked `in_sop` and ends with a byte marked `in_eop`. A stimulation packet must be exactly 5 bytes and a recording packet exactly 7 bytes, counting the header. A packet of any other length is dropped.
- R4: If `gap_open` is low during any byte of a packet, that packet is dropped.
- R5: Outside concurrent mode, an accepted stimulation packet raises `stim_vld` for one cycle. The strobe appears in the cycle after the clock edge that samples the end byte. At the same time `stim_prm` takes the four payload bytes (first received in bits 31:24) and `stim_from_rec` goes to 0.
- R6: An accepted recording packet raises `rec_vld` for one cycle with the same timing as R5. `rec_cfg` takes payload bytes 1–2 (byte 1 in bits 15:8), and `conc_mode` takes bit 15 of that value.
- R7: If a recording packet sets the concurrent bit, the same cycle also raises `stim_vld`, with `stim_prm` set to payload bytes 3–6 and `stim_from_rec` set to 1.
- R8: While `conc_mode` is 1, stimulation packets from the stream are dropped and leave `stim_prm` unchanged.
- R9: Bytes that arrive outside a packet (no start seen) are ignored. A new start byte in the middle of a packet abandons the old packet and begins a new one.
- R10: After reset, all outputs are 0 and concurrent mode is off.
- R11: `stim_prm`, `stim_from_rec`, `rec_cfg` and `conc_mode` change only together with a strobe, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 2 | Strapped chip address |
| gap_open | input | 1 | High while the uplink gap window is open |
| in_vld | input | 1 | A byte is present on `in_byte` |
| in_sop | input | 1 | Current byte is a packet header |
| in_eop | input | 1 | Current byte is the last of its packet |
| in_byte | input | 8 | Demodulated byte |
| stim_vld | output | 1 | One-cycle strobe: new stimulation parameters |
| stim_prm | output | 32 | Stimulation parameters |
| stim_from_rec | output | 1 | Current parameters came from a recording packet |
| rec_vld | output | 1 | One-cycle strobe: new recording configuration |
| rec_cfg | output | 16 | Recording configuration |
| conc_mode | output | 1 | Concurrent record-and-stimulate mode |

## Verification
The bench sends every one of the 256 header values at both legal lengths. This would catch a decoder that accepts a near-miss class code, ignores the address bits, or mixes up the two classes. It also sweeps packet lengths from 2 to 9 bytes for each class, which exposes an off-by-one length check that would accept a packet one byte short or one byte long. It closes the gap window on each byte position in turn, so that a design checking the window only on the header or only on the end byte would pass a corrupted packet. Finally it toggles concurrent mode and sends stray and restarted fragments, so that a design would fail if it let radio stimulation through during concurrent mode, forgot to forward the parameters from a recording packet, or glued a fragment onto the next packet.

// File: rtl/cmd_disp_pkg.sv
package cmd_disp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_STIM = 2'd1,
    CLS_REC  = 2'd2
  } cls_e;
endpackage

// File: rtl/cmd_hdr_check.sv
module cmd_hdr_check
  import cmd_disp_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int CODE_W = BYTE_W - ID_W,
  parameter logic [CODE_W-1:0] STIM_CODE = 6'b010101,
  parameter logic [CODE_W-1:0] REC_CODE  = 6'b101010
) (
  input  logic [BYTE_W-1:0] hdr,
  input  logic [ID_W-1:0]   chip_id,
  output cls_e              cls
);
  logic [CODE_W-1:0] code;
  logic              id_hit;

  assign code   = hdr[BYTE_W-1:ID_W];
  assign id_hit = (hdr[ID_W-1:0] == chip_id);

  always_comb begin
    cls = CLS_NONE;
    if (id_hit) begin
      if (code == STIM_CODE)     cls = CLS_STIM;
      else if (code == REC_CODE) cls = CLS_REC;
    end
  end
endmodule

// File: rtl/cmd_frame_track.sv
module cmd_frame_track
  import cmd_disp_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int STIM_BYTES = 4,
  parameter int CFG_BYTES = 2,
  parameter logic [BYTE_W-ID_W-1:0] STIM_CODE = 6'b010101,
  parameter logic [BYTE_W-ID_W-1:0] REC_CODE  = 6'b101010,
  localparam int PAY_B = CFG_BYTES + STIM_BYTES,
  localparam int PAY_W = PAY_B * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   chip_id,
  input  logic              gap_open,
  input  logic              in_vld,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              pkt_ok,
  output cls_e              pkt_cls,
  output logic [PAY_W-1:0]  pkt_data
);
  localparam int LEN_STIM = 1 + STIM_BYTES;
  localparam int LEN_REC  = 1 + PAY_B;
  localparam int CNT_W    = $clog2(LEN_REC + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic              act_q, act_n;
  logic              bad_q, bad_n;
  cls_e              cls_q, cls_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] pay_q [PAY_B];
  logic [BYTE_W-1:0] lane_in [PAY_B];
  cls_e              hdr_cls;
  logic              shift_en;
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  exp_len;
  logic              bad_w;

  cmd_hdr_check #(
    .ID_W(ID_W), .STIM_CODE(STIM_CODE), .REC_CODE(REC_CODE)
  ) u_hdr (
    .hdr(in_byte), .chip_id(chip_id), .cls(hdr_cls)
  );

  assign shift_en = in_vld && !in_sop && act_q;
  assign cnt_inc  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign exp_len  = (cls_q == CLS_STIM) ? CNT_W'(LEN_STIM) : CNT_W'(LEN_REC);
  assign bad_w    = bad_q || !gap_open || (cnt_inc > exp_len);

  // next-state logic
  always_comb begin
    act_n  = act_q;
    bad_n  = bad_q;
    cls_n  = cls_q;
    cnt_n  = cnt_q;
    pkt_ok = 1'b0;
    if (in_vld) begin
      if (in_sop) begin
        act_n = !in_eop;
        cls_n = hdr_cls;
        bad_n = (hdr_cls == CLS_NONE) || !gap_open;
        cnt_n = CNT_W'(1);
      end else if (act_q) begin
        cnt_n = cnt_inc;
        bad_n = bad_w;
        if (in_eop) begin
          act_n  = 1'b0;
          pkt_ok = !bad_w && (cnt_inc == exp_len);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      bad_q <= 1'b0;
      cls_q <= CLS_NONE;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      bad_q <= bad_n;
      cls_q <= cls_n;
      cnt_q <= cnt_n;
    end
  end

  // payload byte lanes: newest byte in lane 0
  for (genvar k = 0; k < PAY_B; k++) begin : g_lane
    if (k == 0) begin : g_first
      assign lane_in[k] = in_byte;
    end else begin : g_rest
      assign lane_in[k] = pay_q[k-1];
    end
    assign pkt_data[k*BYTE_W +: BYTE_W] = lane_in[k];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pay_q[k] <= '0;
      else if (shift_en) pay_q[k] <= lane_in[k];
    end
  end

  assign pkt_cls = cls_q;

  // R4
  gap_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> gap_open);
  // R1
  cls_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> (cls_q != CLS_NONE));
  // R9
  open_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ok |-> (act_q && !in_sop && in_vld && in_eop));
endmodule

// File: rtl/cmd_route.sv
module cmd_route
  import cmd_disp_pkg::*;
#(
  parameter int STIM_BYTES = 4,
  parameter int CFG_BYTES = 2,
  localparam int PAY_W  = (CFG_BYTES + STIM_BYTES) * BYTE_W,
  localparam int STIM_W = STIM_BYTES * BYTE_W,
  localparam int CFG_W  = CFG_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_ok,
  input  cls_e              pkt_cls,
  input  logic [PAY_W-1:0]  pkt_data,
  output logic              stim_vld,
  output logic [STIM_W-1:0] stim_prm,
  output logic              stim_from_rec,
  output logic              rec_vld,
  output logic [CFG_W-1:0]  rec_cfg,
  output logic              conc_mode
);
  localparam int CONC_BIT = PAY_W - 1;

  logic              svld_n, rvld_n, from_n, conc_n;
  logic [STIM_W-1:0] prm_n;
  logic [CFG_W-1:0]  cfg_n;

  always_comb begin
    svld_n = 1'b0;
    rvld_n = 1'b0;
    prm_n  = stim_prm;
    from_n = stim_from_rec;
    cfg_n  = rec_cfg;
    conc_n = conc_mode;
    if (pkt_ok && pkt_cls == CLS_STIM && !conc_mode) begin
      svld_n = 1'b1;
      prm_n  = pkt_data[STIM_W-1:0];
      from_n = 1'b0;
    end
    if (pkt_ok && pkt_cls == CLS_REC) begin
      rvld_n = 1'b1;
      cfg_n  = pkt_data[PAY_W-1 -: CFG_W];
      conc_n = pkt_data[CONC_BIT];
      if (pkt_data[CONC_BIT]) begin
        svld_n = 1'b1;
        prm_n  = pkt_data[STIM_W-1:0];
        from_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stim_vld      <= 1'b0;
      rec_vld       <= 1'b0;
      stim_prm      <= '0;
      stim_from_rec <= 1'b0;
      rec_cfg       <= '0;
      conc_mode     <= 1'b0;
    end else begin
      stim_vld      <= svld_n;
      rec_vld       <= rvld_n;
      stim_prm      <= prm_n;
      stim_from_rec <= from_n;
      rec_cfg       <= cfg_n;
      conc_mode     <= conc_n;
    end
  end

  // R5
  stim_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stim_vld |=> !stim_vld);
  // R6
  rec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_vld |=> !rec_vld);
  // R8
  radio_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_vld && !stim_from_rec) |-> !conc_mode);
  // R7
  conc_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_vld && stim_from_rec) |-> (rec_vld && conc_mode));
  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_vld |-> ($stable(rec_cfg) && $stable(conc_mode)));
  // R11
  prm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stim_vld |-> ($stable(stim_prm) && $stable(stim_from_rec)));
endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
  import cmd_disp_pkg::*;
#(
  parameter int ID_W = 2,
  parameter int STIM_BYTES = 4,
  parameter int CFG_BYTES = 2,
  parameter logic [BYTE_W-ID_W-1:0] STIM_CODE = 6'b010101,
  parameter logic [BYTE_W-ID_W-1:0] REC_CODE  = 6'b101010
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ID_W-1:0]              chip_id,
  input  logic                         gap_open,
  input  logic                         in_vld,
  input  logic                         in_sop,
  input  logic                         in_eop,
  input  logic [BYTE_W-1:0]            in_byte,
  output logic                         stim_vld,
  output logic [STIM_BYTES*BYTE_W-1:0] stim_prm,
  output logic                         stim_from_rec,
  output logic                         rec_vld,
  output logic [CFG_BYTES*BYTE_W-1:0]  rec_cfg,
  output logic                         conc_mode
);
  localparam int PAY_W = (CFG_BYTES + STIM_BYTES) * BYTE_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             pkt_ok;
  cls_e             pkt_cls;
  logic [PAY_W-1:0] pkt_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cmd_frame_track #(
    .ID_W(ID_W), .STIM_BYTES(STIM_BYTES), .CFG_BYTES(CFG_BYTES),
    .STIM_CODE(STIM_CODE), .REC_CODE(REC_CODE)
  ) u_frame (
    .clk(clk), .rst_n(rst_int_n), .chip_id(chip_id), .gap_open(gap_open),
    .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
    .pkt_ok(pkt_ok), .pkt_cls(pkt_cls), .pkt_data(pkt_data)
  );

  cmd_route #(
    .STIM_BYTES(STIM_BYTES), .CFG_BYTES(CFG_BYTES)
  ) u_route (
    .clk(clk), .rst_n(rst_int_n), .pkt_ok(pkt_ok), .pkt_cls(pkt_cls),
    .pkt_data(pkt_data), .stim_vld(stim_vld), .stim_prm(stim_prm),
    .stim_from_rec(stim_from_rec), .rec_vld(rec_vld), .rec_cfg(rec_cfg),
    .conc_mode(conc_mode)
  );
endmodule

// File: tb/tb_cmd_dispatch.sv
module tb_cmd_dispatch;
  localparam logic [5:0] C_STIM = 6'b010101;
  localparam logic [5:0] C_REC  = 6'b101010;
  localparam logic [1:0] MY_ID  = 2'd2;

  logic clk, rst_n, gap_open, in_vld, in_sop, in_eop;
  logic [1:0]  chip_id;
  logic [7:0]  in_byte;
  logic        stim_vld, stim_from_rec, rec_vld, conc_mode;
  logic [31:0] stim_prm;
  logic [15:0] rec_cfg;

  int total = 0, bad = 0;
  int n_stim = 0, n_rec = 0, e_stim = 0, e_rec = 0;
  logic [31:0] e_prm = '0;
  logic [15:0] e_cfg = '0;
  logic        e_from = 1'b0, e_conc = 1'b0;
  logic [7:0]  pkt [16];
  logic        gapv [16];

  cmd_dispatch dut (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id), .gap_open(gap_open),
    .in_vld(in_vld), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
    .stim_vld(stim_vld), .stim_prm(stim_prm), .stim_from_rec(stim_from_rec),
    .rec_vld(rec_vld), .rec_cfg(rec_cfg), .conc_mode(conc_mode)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (stim_vld) n_stim++;
    if (rec_vld)  n_rec++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(n_stim == e_stim, {tag, " stim count"}, 64'(n_stim), 64'(e_stim));
    chk(n_rec == e_rec, {tag, " rec count"}, 64'(n_rec), 64'(e_rec));
    chk(stim_prm == e_prm, {tag, " stim_prm"}, 64'(stim_prm), 64'(e_prm));
    chk(stim_from_rec == e_from, {tag, " from_rec"}, 64'(stim_from_rec), 64'(e_from));
    chk(rec_cfg == e_cfg, {tag, " rec_cfg"}, 64'(rec_cfg), 64'(e_cfg));
    chk(conc_mode == e_conc, {tag, " conc_mode"}, 64'(conc_mode), 64'(e_conc));
  endtask

  task automatic send(input int n, input bit use_sop, input bit use_eop);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld   = 1'b1;
      in_sop   = use_sop && (i == 0);
      in_eop   = use_eop && (i == n - 1);
      in_byte  = pkt[i];
      gap_open = gapv[i];
    end
    @(negedge clk);
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; gap_open = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // expected-value model built from the requirements
  task automatic predict(input int n);
    bit g = 1'b1;
    for (int i = 0; i < n; i++) g &= gapv[i];
    if (g && pkt[0][1:0] == MY_ID) begin
      if (pkt[0][7:2] == C_STIM && n == 5 && !e_conc) begin
        e_stim++; e_prm = {pkt[1], pkt[2], pkt[3], pkt[4]}; e_from = 1'b0;
      end else if (pkt[0][7:2] == C_REC && n == 7) begin
        e_rec++; e_cfg = {pkt[1], pkt[2]}; e_conc = pkt[1][7];
        if (pkt[1][7]) begin
          e_stim++; e_prm = {pkt[3], pkt[4], pkt[5], pkt[6]}; e_from = 1'b1;
        end
      end
    end
  endtask

  task automatic fill(input logic [7:0] h, input int seed, input bit conc);
    pkt[0] = h;
    for (int i = 1; i < 16; i++) begin
      pkt[i] = 8'((seed * 7 + i * 29 + 3) & 255);
      gapv[i] = 1'b1;
    end
    gapv[0] = 1'b1;
    pkt[1][7] = conc;
  endtask

  task automatic run(input int n);
    send(n, 1'b1, 1'b1);
    predict(n);
  endtask

  initial begin
    rst_n = 1'b0; chip_id = MY_ID; gap_open = 1'b1;
    in_vld = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_byte = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check_all("R10 reset");

    // R1 R2 R3 R5 R6: every header byte at both legal lengths
    for (int h = 0; h < 256; h++) begin
      fill(8'(h), h, 1'b0);
      run(5);
      check_all("R1/R2 hdr sweep stim-len R5");
      fill(8'(h), h + 300, 1'b0);
      run(7);
      check_all("R1/R2 hdr sweep rec-len R6");
    end

    // R3 length sweep per class
    for (int n = 2; n < 10; n++) begin
      fill({C_STIM, MY_ID}, n + 40, 1'b0);
      run(n);
      check_all("R3 stim length");
      fill({C_REC, MY_ID}, n + 80, 1'b0);
      run(n);
      check_all("R3 rec length");
    end

    // R4 gap closed on each byte position
    for (int j = 0; j < 5; j++) begin
      fill({C_STIM, MY_ID}, j + 120, 1'b0);
      gapv[j] = 1'b0;
      run(5);
      check_all("R4 stim gap closed");
    end
    for (int j = 0; j < 7; j++) begin
      fill({C_REC, MY_ID}, j + 140, 1'b0);
      gapv[j] = 1'b0;
      run(7);
      check_all("R4 rec gap closed");
    end

    // R7 enter concurrent mode
    fill({C_REC, MY_ID}, 200, 1'b1);
    run(7);
    check_all("R7 conc enter");
    // R8 radio stimulation refused, R11 prm held
    fill({C_STIM, MY_ID}, 201, 1'b0);
    run(5);
    check_all("R8 radio blocked R11");
    fill({C_REC, MY_ID}, 202, 1'b1);
    run(7);
    check_all("R7 conc forward again");
    fill({C_REC, MY_ID}, 203, 1'b0);
    run(7);
    check_all("R6 conc leave");
    fill({C_STIM, MY_ID}, 204, 1'b0);
    run(5);
    check_all("R5 radio stim after conc");

    // R9 stray bytes without start are ignored
    fill({C_STIM, MY_ID}, 210, 1'b0);
    send(5, 1'b0, 1'b1);
    check_all("R9 stray bytes");
    // R9 restart: fragment then a full packet
    fill({C_STIM, MY_ID}, 211, 1'b0);
    send(3, 1'b1, 1'b0);
    fill({C_STIM, MY_ID}, 212, 1'b0);
    run(5);
    check_all("R9 restart");
    fill({C_REC, MY_ID}, 213, 1'b0);
    send(4, 1'b1, 1'b0);
    fill({C_STIM, MY_ID}, 214, 1'b0);
    run(5);
    check_all("R9 restart rec frag");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule